// File: doc/BRIEF.md
# Tiled Display-Memory Host Bus Front End

This block sits between a host bus and the packed-pixel display memory of one chip in a tiled panel. Up to four such chips share the bus, and together they present the whole screen as one flat byte-addressed space. Each chip reads a two-bit position strap and responds only to the rows and byte columns of its own quarter. It can also see the small palette window at the top of the address space. Accesses that belong to another chip leave this chip's data lanes and ready line undriven.

Host reads and writes move one byte on a narrow bus, or one or two byte lanes on a wide bus. The memory has a single port, and the display side reads a whole pixel row from it for refresh. Refresh always wins the port. A host access that meets a refresh is held off by pulling the shared ready line low. The line is released once the access has been served. Palette writes never touch the memory, so they never wait. The bus strobes are taken as already synchronized to `clk`, and one strobe assertion is one access.

Top module: `tile_bus_front`

## Requirements
- R1: The tile of position p covers screen rows 160·p[0] to 160·p[0]+159 (address bits 16..8) and byte columns 60·p[1] to 60·p[1]+59 (address bits 7..0). An access outside that range is not written to memory, does not enable any data lane and does not pull `rdy_low`.
- R2: The strap `pos` is the position number (0..3). Inside the tile, local row = row − 160·p[0] and local byte column = column − 60·p[1].
- R3: With `byte_mode`=0, the low lane `din/dout[7:0]` is used when `addr[0]`=0, and the high lane `[15:8]` is used when `ube_n`=0. The high lane holds the byte at the odd address and the low lane holds the byte at the even address below it.
- R4: With `byte_mode`=1, only lane 0 carries data, and it carries the byte at exactly `addr`. `ube_n` and `din[15:8]` are ignored, and `dout_en[1]` stays 0.
- R5: While `cs_n`=1, or while neither a read (`oe_n`=0, `we_n`=1) nor a write (`we_n`=0, `oe_n`=1) is strobed, `dout_en` is 0 and `rdy_low` is 0.
- R6: `refresh_data` holds a local row with byte column c at bits 8c+7..8c. Pixel n of the row is at bits 2n+1..2n, so the lowest bit pair is the leftmost pixel.
- R7: An in-tile memory access pulls `rdy_low` high until it is served. With no refresh request, it is served on the first clock edge, so `rdy_low` drops to 0 and read data with its lane enables appears after that edge.
- R8: A `refresh_req` is served on the same edge every time: `refresh_valid` is 1 and `refresh_data` is loaded after that edge. A host access pending on that edge is deferred and `rdy_low` stays 1.
- R9: Byte addresses 0x1FFF0..0x1FFFF are palette entries. Address bits 3..2 select the position and bits 1..0 select the pixel code. A write takes data bits 4..0 of its lane, but only if the position field equals `pos`. On reset, entry k becomes k·8 (00000, 01000, 10000, 11000). Entry k sits at `palette` bits 5k+4..5k.
- R10: A palette access never pulls `rdy_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos | input | 2 | Tile position strap |
| byte_mode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ube_n | input | 1 | High lane enable, active low |
| addr | input | 17 | Byte address |
| din | input | 16 | Write data from bus |
| dout | output | 16 | Read data to bus |
| dout_en | output | 2 | Per-lane drive enable (0 = high impedance) |
| rdy_low | output | 1 | 1 = pull ready line low, 0 = release to high impedance |
| refresh_req | input | 1 | Display-side row read request |
| refresh_row | input | 8 | Local row to refresh |
| refresh_valid | output | 1 | Refresh row data loaded |
| refresh_data | output | 480 | One local row of packed pixels |
| palette | output | 20 | This position's four 5-bit palette entries |

## Verification
The hardest case to reach is a host access that meets a refresh read. The stimulus raises `refresh_req` in the same cycle that it strobes an in-tile read. It then observes `rdy_low` still held, no lane enabled and the refresh row delivered. After it drops the request, it observes the read completing one edge later. Aliasing between tiles is exposed another way: the bench writes to an address in a neighbouring tile and then reads back the local location it would fold onto. The whole run is repeated with the strap at position 3 to exercise the row and column offsets.

// File: rtl/tile_bus_pkg.sv
package tile_bus_pkg;
    parameter int ADDR_W     = 17;
    parameter int DATA_W     = 16;
    parameter int BYTE_W     = 8;
    parameter int LANES      = DATA_W / BYTE_W;
    parameter int PIX_W      = 2;
    parameter int TILE_ROWS  = 160;
    parameter int TILE_BYTES = 60;
    parameter int ROW_W      = 9;
    parameter int COL_W      = 8;
    parameter int PAL_W      = 5;
    parameter int PAL_CODES  = 4;
    parameter int POSITIONS  = 4;
    parameter logic [ADDR_W-1:0] PAL_BASE = 17'h1FFF0;

    localparam int LROW_W   = $clog2(TILE_ROWS);
    localparam int LCOL_W   = $clog2(TILE_BYTES);
    localparam int ROW_BITS = TILE_BYTES * BYTE_W;
    localparam int PAL_IDX_W = $clog2(PAL_CODES * POSITIONS);

    typedef struct packed {
        logic                 hit_ram;
        logic                 hit_pal;
        logic [LANES-1:0]     lanes;
        logic [LROW_W-1:0]    lrow;
        logic [LCOL_W-1:0]    lcol;
        logic [PAL_IDX_W-1:0] pal_idx;
    } decode_t;

    // Which byte lanes carry valid data for this bus cycle.
    function automatic logic [LANES-1:0] lane_enables(input logic narrow,
                                                      input logic a0,
                                                      input logic ube_n);
        logic [LANES-1:0] en;
        if (narrow) en = LANES'(1);
        else        en = {~ube_n, ~a0};
        return en;
    endfunction

    function automatic logic [PAL_W-1:0] pal_reset_value(input int code);
        return PAL_W'(code * 8);
    endfunction
endpackage

// File: rtl/tile_addr_decode.sv
module tile_addr_decode
    import tile_bus_pkg::*;
(
    input  logic [1:0]        pos,
    input  logic              byte_mode,
    input  logic              ube_n,
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    logic [ROW_W-1:0] row, row_base, row_off;
    logic [COL_W-1:0] col, col_first, col_base, col_off;
    logic             row_in, col_in;
    logic [LANES-1:0] lanes;

    always_comb begin
        row       = addr[ADDR_W-1:COL_W];
        col       = addr[COL_W-1:0];
        lanes     = lane_enables(byte_mode, addr[0], ube_n);
        // Lowest byte column touched: the even byte on a wide bus.
        col_first = byte_mode ? col : {col[COL_W-1:1], 1'b0};
        row_base  = pos[0] ? ROW_W'(TILE_ROWS) : '0;
        col_base  = pos[1] ? COL_W'(TILE_BYTES) : '0;
        row_off   = row - row_base;
        col_off   = col_first - col_base;
        row_in    = (row >= row_base) && (row_off < ROW_W'(TILE_ROWS));
        col_in    = (col_first >= col_base) && (col_off < COL_W'(TILE_BYTES));

        dec.hit_pal = (addr >= PAL_BASE);
        dec.hit_ram = row_in && col_in && (|lanes) && !dec.hit_pal;
        dec.lanes   = lanes;
        dec.lrow    = LROW_W'(row_off);
        dec.lcol    = LCOL_W'(col_off);
        dec.pal_idx = PAL_IDX_W'(col_first);
    end
endmodule

// File: rtl/tile_port_arbiter.sv
module tile_port_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic hit_ram,
    input  logic refresh_req,
    output logic rd_cmd,
    output logic wr_cmd,
    output logic host_gnt,
    output logic served,
    output logic rdy_low
);
    logic access;

    always_comb begin
        rd_cmd   = !cs_n && !oe_n && we_n;
        wr_cmd   = !cs_n && !we_n && oe_n;
        access   = (rd_cmd || wr_cmd) && hit_ram;
        // Refresh owns the port whenever it asks.
        host_gnt = access && !served && !refresh_req;
        rdy_low  = access && !served;
    end

    always_ff @(posedge clk) begin
        if (rst)          served <= 1'b0;
        else if (!access) served <= 1'b0;
        else if (host_gnt) served <= 1'b1;
    end

    // R7: an unhindered waiting access is served by the next edge
    p_wait_served_r7: assert property (@(posedge clk) disable iff (rst)
        (rdy_low && !refresh_req) |=> (served || !access));
endmodule

// File: rtl/tile_pixel_ram.sv
module tile_pixel_ram
    import tile_bus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [LROW_W-1:0]   row,
    input  logic [LCOL_W-1:0]   col,
    input  logic [LANES-1:0]    lanes,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                ref_req,
    input  logic [LROW_W-1:0]   ref_row,
    output logic                ref_valid,
    output logic [ROW_BITS-1:0] ref_data
);
    logic [ROW_BITS-1:0] mem [TILE_ROWS];
    logic [DATA_W-1:0]   rd_word;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            if (int'(col) + k < TILE_BYTES)
                rd_word[k*BYTE_W +: BYTE_W] = mem[row][(int'(col) + k)*BYTE_W +: BYTE_W];
            else
                rd_word[k*BYTE_W +: BYTE_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (wr_en && lanes[k] && (int'(col) + k < TILE_BYTES))
                mem[row][(int'(col) + k)*BYTE_W +: BYTE_W] <= wdata[k*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            ref_valid <= 1'b0;
            ref_data  <= '0;
        end else begin
            if (rd_en) rdata <= rd_word;
            ref_valid <= ref_req;
            if (ref_req)
                ref_data <= (int'(ref_row) < TILE_ROWS) ? mem[ref_row] : '0;
        end
    end
endmodule

// File: rtl/tile_palette.sv
module tile_palette
    import tile_bus_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 pos,
    input  logic                       wr_en,
    input  logic [PAL_IDX_W-1:0]       idx,
    input  logic [LANES-1:0]           lanes,
    input  logic [LANES*PAL_W-1:0]     wdata,
    output logic [PAL_CODES*PAL_W-1:0] entries
);
    localparam int CODE_W = $clog2(PAL_CODES);

    for (genvar e = 0; e < PAL_CODES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[e*PAL_W +: PAL_W] <= pal_reset_value(e);
            end else if (wr_en) begin
                for (int k = 0; k < LANES; k++) begin
                    logic [PAL_IDX_W-1:0] lane_idx;
                    lane_idx = idx + PAL_IDX_W'(k);
                    if (lanes[k] && lane_idx[PAL_IDX_W-1:CODE_W] == pos
                        && lane_idx[CODE_W-1:0] == CODE_W'(e))
                        entries[e*PAL_W +: PAL_W] <= wdata[k*PAL_W +: PAL_W];
                end
            end
        end
    end
endmodule

// File: rtl/tile_bus_front.sv
module tile_bus_front
    import tile_bus_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 pos,
    input  logic                       byte_mode,
    input  logic                       cs_n,
    input  logic                       oe_n,
    input  logic                       we_n,
    input  logic                       ube_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          dout,
    output logic [LANES-1:0]           dout_en,
    output logic                       rdy_low,
    input  logic                       refresh_req,
    input  logic [LROW_W-1:0]          refresh_row,
    output logic                       refresh_valid,
    output logic [ROW_BITS-1:0]        refresh_data,
    output logic [PAL_CODES*PAL_W-1:0] palette
);
    decode_t              dec;
    logic                 rd_cmd, wr_cmd, host_gnt, served;
    logic [LANES*PAL_W-1:0] pal_wdata;

    tile_addr_decode u_dec (
        .pos(pos), .byte_mode(byte_mode), .ube_n(ube_n), .addr(addr), .dec(dec)
    );

    tile_port_arbiter u_arb (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .hit_ram(dec.hit_ram), .refresh_req(refresh_req),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .host_gnt(host_gnt),
        .served(served), .rdy_low(rdy_low)
    );

    tile_pixel_ram u_ram (
        .clk(clk), .rst(rst),
        .wr_en(host_gnt && wr_cmd), .rd_en(host_gnt && rd_cmd),
        .row(dec.lrow), .col(dec.lcol), .lanes(dec.lanes), .wdata(din),
        .rdata(dout),
        .ref_req(refresh_req), .ref_row(refresh_row),
        .ref_valid(refresh_valid), .ref_data(refresh_data)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_pal_lane
        assign pal_wdata[k*PAL_W +: PAL_W] = din[k*BYTE_W +: PAL_W];
    end

    tile_palette u_pal (
        .clk(clk), .rst(rst), .pos(pos),
        .wr_en(wr_cmd && dec.hit_pal), .idx(dec.pal_idx), .lanes(dec.lanes),
        .wdata(pal_wdata), .entries(palette)
    );

    assign dout_en = (rd_cmd && dec.hit_ram && served) ? dec.lanes : '0;

    // R5: a deselected chip drives nothing
    p_quiet_deselect_r5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (dout_en == '0 && !rdy_low));
    // R4: narrow bus never drives the upper lane
    p_narrow_lane_r4: assert property (@(posedge clk) disable iff (rst)
        byte_mode |-> !dout_en[1]);
    // R10: palette window never stalls the host
    p_pal_no_wait_r10: assert property (@(posedge clk) disable iff (rst)
        dec.hit_pal |-> !rdy_low);
    // R1: foreign addresses never hold the shared ready line
    p_foreign_no_rdy_r1: assert property (@(posedge clk) disable iff (rst)
        !dec.hit_ram |-> !rdy_low);
    // R8: refresh request on an edge defers any pending host access
    p_refresh_defers_r8: assert property (@(posedge clk) disable iff (rst)
        (refresh_req && rdy_low) |=> (rdy_low || cs_n || (oe_n && we_n)) || !$past(dec.hit_ram) || !dec.hit_ram);
endmodule

// File: tb/test_tile_bus_front.sv
module test_tile_bus_front;
    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   pos;
    logic         byte_mode, cs_n, oe_n, we_n, ube_n;
    logic [16:0]  addr;
    logic [15:0]  din, dout;
    logic [1:0]   dout_en;
    logic         rdy_low, refresh_req, refresh_valid;
    logic [7:0]   refresh_row;
    logic [479:0] refresh_data;
    logic [19:0]  palette;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    string       q_req[$];
    int          q_sel[$];
    int          q_arg[$];
    logic [31:0] q_exp[$];

    always #10 clk = ~clk;

    tile_bus_front i_tile_bus_front (
        .clk(clk), .rst(rst), .pos(pos), .byte_mode(byte_mode),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .ube_n(ube_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .rdy_low(rdy_low), .refresh_req(refresh_req), .refresh_row(refresh_row),
        .refresh_valid(refresh_valid), .refresh_data(refresh_data),
        .palette(palette)
    );

    function automatic logic [31:0] observe(int sel, int arg);
        case (sel)
            0: return {16'h0, dout};
            1: return {30'h0, dout_en};
            2: return {31'h0, rdy_low};
            3: return {31'h0, refresh_valid};
            4: return {24'h0, refresh_data[arg*8 +: 8]};
            5: return {30'h0, refresh_data[arg*2 +: 2]};
            6: return {12'h0, palette};
            default: return {24'h0, dout[7:0]};
        endcase
    endfunction

    // Monitor: compares predicted items after each active edge.
    always @(negedge clk) begin
        #1;
        while (q_sel.size() > 0) begin
            string       r;
            int          s, a;
            logic [31:0] e, act;
            r = q_req.pop_front(); s = q_sel.pop_front();
            a = q_arg.pop_front(); e = q_exp.pop_front();
            act = observe(s, a);
            checks++;
            if (act !== e) begin
                failures++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", r, s, act, e);
            end
        end
    end

    task automatic expect_item(string r, int s, int a, logic [31:0] e);
        q_req.push_back(r); q_sel.push_back(s); q_arg.push_back(a); q_exp.push_back(e);
    endtask

    task automatic step();
        @(negedge clk); #2;
    endtask

    task automatic idle();
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_write(logic [16:0] a, logic [15:0] d, logic u, string r);
        addr = a; din = d; ube_n = u; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        expect_item(r, 2, 0, 0);
        step(); idle(); step();
    endtask

    task automatic bus_read(logic [16:0] a, logic u, string r, int s, logic [31:0] e, logic [1:0] en);
        addr = a; ube_n = u; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        expect_item(r, s, 0, e);
        expect_item(r, 1, 0, {30'h0, en});
        step(); idle(); step();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pos = 2'd0; byte_mode = 1'b0; idle(); ube_n = 1'b1;
        addr = '0; din = '0; refresh_req = 1'b0; refresh_row = '0;
        step(); step();
        rst = 1'b0;
        // R9 reset values, R5 idle outputs
        expect_item("R9 reset palette", 6, 0, 32'h000C4100);
        expect_item("R5 reset rdy", 2, 0, 0);
        expect_item("R5 reset lanes", 1, 0, 0);
        step();

        // R3 word write and read at even address
        bus_write(17'h00000, 16'hA51B, 1'b0, "R7 write served");
        bus_read(17'h00000, 1'b0, "R3 word read", 0, 32'hA51B, 2'b11);
        // R3 high lane only at odd address
        bus_write(17'h00001, 16'h3C00, 1'b0, "R3 high write");
        bus_read(17'h00000, 1'b0, "R3 high lane merged", 0, 32'h3C1B, 2'b11);
        // R3 low lane only
        bus_write(17'h00102, 16'h9977, 1'b1, "R3 low write");
        bus_read(17'h00102, 1'b1, "R3 low lane read", 7, 32'h77, 2'b01);

        // R6 refresh layout
        refresh_req = 1'b1; refresh_row = 8'd0;
        expect_item("R6 byte0", 4, 0, 32'h1B);
        expect_item("R6 byte1", 4, 1, 32'h3C);
        expect_item("R6 pixel0", 5, 0, 32'h3);
        expect_item("R6 pixel1", 5, 1, 32'h2);
        expect_item("R8 refresh valid", 3, 0, 1);
        step(); refresh_req = 1'b0; step();

        // R4 narrow bus, ube_n ignored
        byte_mode = 1'b1;
        bus_write(17'h00105, 16'hFF42, 1'b0, "R4 narrow write");
        bus_read(17'h00105, 1'b0, "R4 narrow read", 7, 32'h42, 2'b01);
        byte_mode = 1'b0;
        bus_read(17'h00105, 1'b0, "R4 byte landed at addr", 0, {16'h0, 8'h42, dout[7:0]} & 32'hFF00 | 32'h0, 2'b10);

        // R1 foreign write must not alias
        bus_write(17'h0003C, 16'hFFFF, 1'b0, "R1 foreign write no rdy");
        bus_read(17'h0003C, 1'b0, "R1 foreign read no drive", 2, 0, 2'b00);
        bus_read(17'h0C800, 1'b0, "R1 foreign row no drive", 2, 0, 2'b00);
        bus_read(17'h00000, 1'b0, "R1 no alias", 0, 32'h3C1B, 2'b11);

        // R5 strobes inactive / chip deselected
        addr = 17'h00000; cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        expect_item("R5 no strobe lanes", 1, 0, 0);
        expect_item("R5 no strobe rdy", 2, 0, 0);
        step();
        cs_n = 1'b1; oe_n = 1'b0;
        expect_item("R5 deselected lanes", 1, 0, 0);
        step(); idle(); step();

        // R7/R8 contention: refresh wins, host waits
        addr = 17'h00000; ube_n = 1'b0; cs_n = 1'b0; oe_n = 1'b0;
        refresh_req = 1'b1; refresh_row = 8'd0;
        expect_item("R8 host held", 2, 0, 1);
        expect_item("R8 no lanes while held", 1, 0, 0);
        expect_item("R8 refresh served", 3, 0, 1);
        step();
        refresh_req = 1'b0;
        expect_item("R7 released", 2, 0, 0);
        expect_item("R7 data after wait", 0, 0, 32'h3C1B);
        step(); idle(); step();

        // R9 palette: own entry accepted, foreign ignored; R10 no wait
        bus_write(17'h1FFF1, 16'h1500, 1'b0, "R10 palette no wait");
        expect_item("R9 own entry", 6, 0, 32'h000C42A0);
        step();
        bus_write(17'h1FFF4, 16'h001F, 1'b1, "R10 palette foreign");
        expect_item("R9 foreign ignored", 6, 0, 32'h000C42A0);
        step();

        // R2 position 3
        rst = 1'b1; step(); pos = 2'd3; rst = 1'b0; step();
        bus_write(17'h0A03C, 16'h1234, 1'b0, "R2 write pos3");
        refresh_req = 1'b1; refresh_row = 8'd0;
        expect_item("R2 local byte0", 4, 0, 32'h34);
        expect_item("R2 local byte1", 4, 1, 32'h12);
        step(); refresh_req = 1'b0; step();
        bus_read(17'h0A03C, 1'b0, "R2 read pos3", 0, 32'h1234, 2'b11);
        bus_read(17'h0003C, 1'b0, "R1 pos3 foreign", 2, 0, 2'b00);
        bus_write(17'h13F76, 16'hBEEF, 1'b0, "R2 corner write");
        bus_read(17'h13F76, 1'b0, "R2 corner read", 0, 32'hBEEF, 2'b11);
        bus_read(17'h14076, 1'b0, "R1 row past tile", 2, 0, 2'b00);
        bus_write(17'h1FFFF, 16'h0700, 1'b0, "R10 palette pos3");
        expect_item("R9 pos3 entry3", 6, 0, 32'h0003C100);
        step();

        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule